// File: doc/BRIEF.md
# Byte-Bus Memory Map Decoder

This block sits behind a 16-bit-address, byte-wide bus and routes every access to one of five places: the serial port register window, on-chip RAM, the internal register field, read-only program memory or an external space. A request can move one byte or one 16-bit word. A word is carried out as two byte accesses in consecutive cycles: the high byte goes at the given address and the low byte at the next address, wrapping modulo 65536. Wider request addresses are masked to 16 bits before any decode.

Every byte access drives a one-cycle log output with the byte address, the direction and a region code. A bench can follow the decode from this output without looking inside the block. Program memory returns a computed image and drops writes silently, although the write is still logged. The external space is a small tagged backing store, and any location never written there reads as 0xFF. The serial window holds six byte registers with fixed reset values. A write to its transmit-data register raises the transmit-empty flag and, when transmit is enabled, emits the byte on a strobe.

Top module: `mem_map_decoder`

## Requirements
- R1: Only bits [15:0] of `req_addr` take part in the decode. An access at an address with upper bits set reaches the same location, and logs the same address, as one with those bits clear.
- R2: Addresses 0xF680–0xFE7F (inclusive) decode to RAM, region code 2. A written byte reads back unchanged.
- R3: Addresses 0xFE80–0xFFFF, outside the serial window, decode to the register field, region code 3. A written byte reads back unchanged.
- R4: The serial window 0xFED8–0xFEDD decodes first, as region code 4. Its registers reset to 0x00, 0xFF, 0x0C, 0xFF, 0x87 and 0x00, in address order.
- R5: A write to 0xFEDB sets bit 7 (0x80) of the status register at 0xFEDC. If bit 5 (0x20) of the control register at 0xFEDA is set, the cycle after the byte access also drives `tx_valid` high for one cycle, with `tx_byte` equal to the written value. Otherwise no byte is emitted.
- R6: Addresses below 0x8000 decode to program memory, region code 0. A read returns address[15:8] XOR address[7:0]. A write is logged with `log_write`=1 but leaves the contents unchanged.
- R7: Addresses 0x8000–0xF67F decode to external space, region code 1. A location never written reads 0xFF, and a written one reads back its value. The store holds up to EXT_SLOTS distinct addresses.
- R8: A word access makes two log entries on consecutive cycles: the high byte at A, then the low byte at (A+1) mod 65536. A word read returns {byte at A, byte at A+1}. A byte read returns {0x00, byte}.
- R9: `log_valid` is high for exactly one cycle per byte access, and `req_ready` is low throughout. For a read, `rd_valid` is high for one cycle, on the cycle after the last byte access.
- R10: After reset, `req_ready` is 1 and `log_valid`, `rd_valid` and `tx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | IN_ADDR_W | Request address; only bits [15:0] are used |
| req_wdata | input | 16 | Write data; a byte write uses bits [7:0] |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read result |
| log_valid | output | 1 | A byte access is taking place this cycle |
| log_write | output | 1 | Direction of the logged byte access |
| log_region | output | 3 | Region code of the logged byte access |
| log_addr | output | 16 | Byte address of the logged access |
| tx_valid | output | 1 | Serial transmit byte strobe |
| tx_byte | output | 8 | Byte emitted on the serial strobe |

## Verification
Two functions can fall in the same cycle. First, a single transmit-data write must both raise the status flag and emit the serial byte. The bench writes 0xFEDB with transmit enable off and then on, and checks the strobe on the cycle after the access; a later status read must show bit 7. Second, one word access can cross a region boundary, or wrap from 0xFFFF to 0x0000, so that its two byte halves log different region codes on consecutive cycles. The bench runs word accesses at 0xF67F, 0xFE7F and 0xFFFF, and its behavioural reference judges each half's region, address and data on its own cycle.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  typedef enum logic [2:0] {
    RG_ROM    = 3'd0,
    RG_EXT    = 3'd1,
    RG_RAM    = 3'd2,
    RG_REGF   = 3'd3,
    RG_SERIAL = 3'd4
  } region_e;

  localparam logic [15:0] RAM_LO  = 16'hF680;
  localparam logic [15:0] RAM_HI  = 16'hFE7F;
  localparam logic [15:0] REGF_LO = 16'hFE80;
  localparam logic [15:0] SER_LO  = 16'hFED8;
  localparam logic [15:0] SER_HI  = 16'hFEDD;
  localparam int RAM_DEPTH  = int'(RAM_HI) - int'(RAM_LO) + 1;
  localparam int REGF_DEPTH = 65536 - int'(REGF_LO);
  localparam int SER_REGS   = int'(SER_HI) - int'(SER_LO) + 1;

  localparam logic [2:0] SER_CTRL   = 3'd2;
  localparam logic [2:0] SER_TXDATA = 3'd3;
  localparam logic [2:0] SER_STATUS = 3'd4;

  // Priority: serial window, RAM, register field, program memory, external.
  function automatic region_e decode_region(input logic [15:0] a,
                                            input logic [15:0] rom_end);
    if (a >= SER_LO && a <= SER_HI)      return RG_SERIAL;
    else if (a >= RAM_LO && a <= RAM_HI) return RG_RAM;
    else if (a >= REGF_LO)               return RG_REGF;
    else if (a < rom_end)                return RG_ROM;
    else                                 return RG_EXT;
  endfunction

  function automatic logic [7:0] rom_byte(input logic [15:0] a);
    return a[15:8] ^ a[7:0];
  endfunction

  function automatic logic [7:0] ser_reset(input int i);
    case (i)
      1:       return 8'hFF;
      2:       return 8'h0C;
      3:       return 8'hFF;
      4:       return 8'h87;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/mmd_byte_array.sv
module mmd_byte_array #(
  parameter logic [15:0] BASE  = 16'h0000,
  parameter int          DEPTH = 256,
  localparam int         IW    = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata
);
  logic [7:0]    mem [DEPTH];
  logic [IW-1:0] idx;

  assign idx   = IW'(addr - BASE);
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end
endmodule

// File: rtl/mmd_ext_store.sv
module mmd_ext_store #(
  parameter int SLOTS = 8,
  localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata
);
  logic [15:0]   tag  [SLOTS];
  logic [7:0]    data [SLOTS];
  logic [SLOTS-1:0] vld;
  logic [PW-1:0] ptr, hit_idx;
  logic          hit;

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    rdata   = 8'hFF;
    for (int i = 0; i < SLOTS; i++) begin
      if (vld[i] && tag[i] == addr) begin
        hit     = 1'b1;
        hit_idx = PW'(i);
        rdata   = data[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (we && !hit) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PW'(SLOTS - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      if (hit) data[hit_idx] <= wdata;
      else begin
        data[ptr] <= wdata;
        tag[ptr]  <= addr;
      end
    end
  end
endmodule

// File: rtl/mmd_serial.sv
module mmd_serial
  import mmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  logic [7:0] regs [SER_REGS];

  assign rdata = (int'(idx) < SER_REGS) ? regs[idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SER_REGS; i++) regs[i] <= ser_reset(i);
      tx_valid <= 1'b0;
      tx_byte  <= 8'h00;
    end else begin
      tx_valid <= 1'b0;
      if (we) begin
        regs[idx] <= wdata;
        if (idx == SER_TXDATA) begin
          regs[SER_STATUS] <= regs[SER_STATUS] | 8'h80;
          tx_valid         <= regs[SER_CTRL][5];
          tx_byte          <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
  import mmd_pkg::*;
#(
  parameter int          IN_ADDR_W = 20,
  parameter logic [15:0] ROM_END   = 16'h8000,
  parameter int          EXT_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic                 req_word,
  input  logic [IN_ADDR_W-1:0] req_addr,
  input  logic [15:0]          req_wdata,
  output logic                 rd_valid,
  output logic [15:0]          rd_data,
  output logic                 log_valid,
  output logic                 log_write,
  output logic [2:0]           log_region,
  output logic [15:0]          log_addr,
  output logic                 tx_valid,
  output logic [7:0]           tx_byte
);
  logic        busy, second_byte, is_word, is_write;
  logic [15:0] cur_addr, wbuf;
  logic [7:0]  hi_keep, byte_wdata, rd_byte;
  logic [7:0]  ram_rd, regf_rd, ext_rd, ser_rd;
  logic        last_byte, wr_now;
  region_e     region;

  // Named internal events
  assign region     = decode_region(cur_addr, ROM_END);
  assign last_byte  = !is_word || second_byte;
  assign wr_now     = busy && is_write;
  assign byte_wdata = (is_word && !second_byte) ? wbuf[15:8] : wbuf[7:0];

  assign req_ready  = !busy;
  assign log_valid  = busy;
  assign log_write  = is_write;
  assign log_region = region;
  assign log_addr   = cur_addr;

  mmd_byte_array #(.BASE(RAM_LO), .DEPTH(RAM_DEPTH)) u_ram (
    .clk(clk), .we(wr_now && region == RG_RAM), .addr(cur_addr),
    .wdata(byte_wdata), .rdata(ram_rd));

  // Serial writes are mirrored into the register field storage.
  mmd_byte_array #(.BASE(REGF_LO), .DEPTH(REGF_DEPTH)) u_regf (
    .clk(clk), .we(wr_now && (region == RG_REGF || region == RG_SERIAL)),
    .addr(cur_addr), .wdata(byte_wdata), .rdata(regf_rd));

  mmd_ext_store #(.SLOTS(EXT_SLOTS)) u_ext (
    .clk(clk), .rst_n(rst_n), .we(wr_now && region == RG_EXT),
    .addr(cur_addr), .wdata(byte_wdata), .rdata(ext_rd));

  mmd_serial u_ser (
    .clk(clk), .rst_n(rst_n), .we(wr_now && region == RG_SERIAL),
    .idx(3'(cur_addr - SER_LO)), .wdata(byte_wdata), .rdata(ser_rd),
    .tx_valid(tx_valid), .tx_byte(tx_byte));

  always_comb begin
    case (region)
      RG_ROM:    rd_byte = rom_byte(cur_addr);
      RG_EXT:    rd_byte = ext_rd;
      RG_RAM:    rd_byte = ram_rd;
      RG_REGF:   rd_byte = regf_rd;
      RG_SERIAL: rd_byte = ser_rd;
      default:   rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      second_byte <= 1'b0;
      is_word     <= 1'b0;
      is_write    <= 1'b0;
      cur_addr    <= '0;
      wbuf        <= '0;
      hi_keep     <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy        <= 1'b1;
          second_byte <= 1'b0;
          is_word     <= req_word;
          is_write    <= req_write;
          cur_addr    <= 16'(req_addr);
          wbuf        <= req_wdata;
        end
      end else if (!last_byte) begin
        second_byte <= 1'b1;
        cur_addr    <= cur_addr + 16'd1;
        hi_keep     <= rd_byte;
      end else begin
        busy     <= 1'b0;
        rd_valid <= !is_write;
        rd_data  <= is_word ? {hi_keep, rd_byte} : {8'h00, rd_byte};
      end
    end
  end
endmodule

// File: rtl/mmd_checker.sv
module mmd_checker #(
  parameter logic [15:0] ROM_END = 16'h8000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        log_valid,
  input logic        log_write,
  input logic [2:0]  log_region,
  input logic [15:0] log_addr,
  input logic        rd_valid,
  input logic        tx_valid,
  input logic        second_byte
);
  a_r2_ram_region: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && log_addr >= 16'hF680 && log_addr <= 16'hFE7F |-> log_region == 3'd2);

  a_r4_serial_first: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && log_addr >= 16'hFED8 && log_addr <= 16'hFEDD |-> log_region == 3'd4);

  a_r6_rom_region: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && log_addr < ROM_END |-> log_region == 3'd0);

  a_r8_low_follows: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid && second_byte |-> $past(log_valid) && log_addr == $past(log_addr) + 16'd1);

  a_r9_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    log_valid |-> !req_ready);

  a_r9_read_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(log_valid && !log_write) && !log_valid);

  a_r5_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(log_valid && log_write && log_addr == 16'hFEDB));
endmodule

bind mem_map_decoder mmd_checker #(.ROM_END(ROM_END)) u_chk (.*);

// File: tb/mem_map_decoder_test.sv
module mem_map_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rd_valid, log_valid, log_write, tx_valid;
  logic [15:0] rd_data, log_addr;
  logic [2:0]  log_region;
  logic [7:0]  tx_byte;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] model [int];

  mem_map_decoder uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .log_valid(log_valid), .log_write(log_write), .log_region(log_region),
    .log_addr(log_addr), .tx_valid(tx_valid), .tx_byte(tx_byte));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int ref_region(input int a);
    if (a >= 'hFED8 && a <= 'hFEDD) return 4;
    if (a >= 'hF680 && a <= 'hFE7F) return 2;
    if (a >= 'hFE80) return 3;
    if (a < 'h8000) return 0;
    return 1;
  endfunction

  function automatic logic [7:0] ref_read(input int a);
    if (ref_region(a) == 0) return 8'((a >> 8) ^ a);
    if (model.exists(a)) return model[a];
    return 8'hFF;
  endfunction

  // One request, judged cycle by cycle against the reference.
  task automatic access(input bit wr, input bit wd, input logic [19:0] a,
                        input logic [15:0] d, input string req);
    int n = wd ? 2 : 1;
    logic [15:0] exp_rd = 16'h0000;
    bit exp_tx = 1'b0;
    logic [7:0] exp_txb = 8'h00;
    chk(req_ready == 1'b1, "R9 ready idle", int'(req_ready), 1);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      int ba = (int'(a[15:0]) + k) & 'hFFFF;
      logic [7:0] bd = (wd && k == 0) ? d[15:8] : d[7:0];
      chk(log_valid && req_ready == 1'b0, {req, " R9 log_valid"}, int'(log_valid), 1);
      chk(int'(log_addr) == ba, {req, " R8 log_addr"}, int'(log_addr), ba);
      chk(int'(log_region) == ref_region(ba), {req, " region"}, int'(log_region), ref_region(ba));
      chk(log_write == wr, {req, " direction"}, int'(log_write), int'(wr));
      exp_rd = {exp_rd[7:0], ref_read(ba)};
      exp_tx = 1'b0;
      if (wr && ref_region(ba) != 0) begin
        if (ba == 'hFEDB) begin
          exp_tx  = ref_read('hFEDA) >> 5 & 1;
          exp_txb = bd;
          model['hFEDC] = ref_read('hFEDC) | 8'h80;
        end
        model[ba] = bd;
      end
      @(posedge clk); @(negedge clk);
    end
    chk(log_valid == 1'b0, {req, " R9 log ends"}, int'(log_valid), 0);
    chk(rd_valid == !wr, {req, " R9 rd_valid"}, int'(rd_valid), int'(!wr));
    if (!wr) chk(rd_data == exp_rd, {req, " data"}, int'(rd_data), int'(exp_rd));
    chk(tx_valid == exp_tx, {req, " R5 tx_valid"}, int'(tx_valid), int'(exp_tx));
    if (exp_tx) chk(tx_byte == exp_txb, {req, " R5 tx_byte"}, int'(tx_byte), int'(exp_txb));
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) model['hFED8 + i] = (i == 1 || i == 3) ? 8'hFF :
                                                     (i == 2) ? 8'h0C : (i == 4) ? 8'h87 : 8'h00;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
    chk(log_valid == 1'b0, "R10 log_valid", int'(log_valid), 0);
    chk(rd_valid == 1'b0, "R10 rd_valid", int'(rd_valid), 0);
    chk(tx_valid == 1'b0, "R10 tx_valid", int'(tx_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: serial reset values, decoded ahead of the register field
    for (int i = 0; i < 6; i++) access(1'b0, 1'b0, 20'(16'hFED8 + i), 16'h0, "R4 serial reset");
    // R1: upper address bits ignored
    access(1'b1, 1'b0, 20'hAF700, 16'h00C3, "R1 masked write");
    access(1'b0, 1'b0, 20'h0F700, 16'h0, "R1 masked read");
    // R2: RAM word and byte
    access(1'b1, 1'b1, 20'h0F800, 16'h1234, "R2 ram word write");
    access(1'b0, 1'b1, 20'h0F800, 16'h0, "R2 ram word read");
    access(1'b0, 1'b0, 20'h0F801, 16'h0, "R2 ram low byte");
    // R3: register field
    access(1'b1, 1'b0, 20'h0FF20, 16'h005A, "R3 regf write");
    access(1'b0, 1'b0, 20'h0FF20, 16'h0, "R3 regf read");
    // R5: transmit data write, enable off then on
    access(1'b1, 1'b0, 20'h0FEDC, 16'h0000, "R5 clear status");
    access(1'b1, 1'b0, 20'h0FEDB, 16'h0041, "R5 tx disabled");
    access(1'b0, 1'b0, 20'h0FEDC, 16'h0, "R5 status flag");
    access(1'b1, 1'b0, 20'h0FEDA, 16'h0020, "R5 enable tx");
    access(1'b1, 1'b0, 20'h0FEDB, 16'h0042, "R5 tx enabled");
    // R6: program memory reads computed image, writes dropped
    access(1'b0, 1'b0, 20'h01234, 16'h0, "R6 rom read");
    access(1'b1, 1'b0, 20'h01234, 16'h00EE, "R6 rom write");
    access(1'b0, 1'b0, 20'h01234, 16'h0, "R6 rom unchanged");
    // R7: external space
    access(1'b0, 1'b0, 20'h09000, 16'h0, "R7 ext unwritten");
    access(1'b1, 1'b0, 20'h09000, 16'h0077, "R7 ext write");
    access(1'b0, 1'b0, 20'h09000, 16'h0, "R7 ext read");
    access(1'b0, 1'b0, 20'h09001, 16'h0, "R7 ext neighbour");
    // R8: words crossing region boundaries and wrapping
    access(1'b1, 1'b1, 20'h0F67F, 16'h1122, "R8 ext/ram write");
    access(1'b0, 1'b1, 20'h0F67F, 16'h0, "R8 ext/ram read");
    access(1'b1, 1'b1, 20'h0FE7F, 16'h3344, "R8 ram/regf write");
    access(1'b0, 1'b1, 20'h0FE7F, 16'h0, "R8 ram/regf read");
    access(1'b1, 1'b1, 20'h0FFFF, 16'hABCD, "R8 wrap write");
    access(1'b0, 1'b1, 20'h0FFFF, 16'h0, "R8 wrap read");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule